// File: doc/BRIEF.md
# Serial-Infrared Pulse Codec

This block sits between a UART and an infrared transceiver. On the way out it turns the UART's NRZ transmit line into return-to-zero infrared pulses. A zero bit becomes one short high pulse and a one bit becomes no pulse. On the way in it qualifies incoming pulses, drops glitches, and rebuilds an NRZ receive level for the UART. Bit timing comes from a one-cycle strobe at sixteen times the baud rate. The transmit bit grid restarts on every level change of the UART transmit line.

A link select chooses between raw pass-through and infrared coding. A width select picks the pulse width. In the bit-relative width the pulse covers 3/16 of a bit. In the fixed width the pulse lasts three periods of the system clock divided by an 8-bit divisor, whatever the baud rate. The same divisor sets the shortest receive pulse that is accepted. The link is half-duplex, so the receiver is held idle while the transmitter is active. The intended rate is 115.2 kbit/s or below.

Top module: `sir_codec`

## Requirements
- R1: After reset, with infrared coding selected and both lines idle (`uart_txd`=1, `ir_rx`=0), `ir_tx` is 0 and `uart_rxd` is 1.
- R2: With `sir_mode`=1 and `lp_mode`=0, each zero bit drives `ir_tx` high for exactly 3 tick periods. The pulse starts at the 7th tick and ends at the 10th tick counted from the start of the bit. A level change of `uart_txd` starts a bit, and every further 16 ticks start the next one.
- R3: With infrared coding selected, a one bit produces no pulse on `ir_tx`.
- R4: With `sir_mode`=1 and `lp_mode`=1, each zero bit drives `ir_tx` high for exactly 3×N system clocks, starting at the 7th tick of the bit. N is the divisor value, and the pulse length does not depend on the tick rate.
- R5: A divisor value of 0 acts as N=256, both for the transmit width and for the receive filter.
- R6: With infrared coding selected and the transmitter idle, a receive pulse of at least N clocks drives `uart_rxd` to 0. It stays 0 for 16 ticks and then returns to 1. The input passes through a two-flop synchronizer.
- R7: A receive pulse shorter than N clocks leaves `uart_rxd` at 1.
- R8: While `uart_txd` is low or a fixed-width pulse is still running, `ir_rx` is ignored and the pulse filter is cleared. A pulse that overlaps the end of transmission counts only the clocks after transmission ends.
- R9: With `sir_mode`=0, `ir_tx` follows `uart_txd` and `uart_rxd` follows `ir_rx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the reference for the divided clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick16 | input | 1 | One-cycle strobe at 16× the baud rate |
| sir_mode | input | 1 | 1 = infrared coding, 0 = raw pass-through |
| lp_mode | input | 1 | 1 = fixed divided-clock pulse width, 0 = 3/16-bit width |
| lp_div | input | 8 | Divisor N for the divided clock, 0 means 256 |
| uart_txd | input | 1 | NRZ transmit line from the UART |
| uart_rxd | output | 1 | Rebuilt NRZ receive line to the UART |
| ir_rx | input | 1 | Active-high pulse from the infrared receiver |
| ir_tx | output | 1 | Active-high pulse to the infrared emitter |

## Verification
The functions that can land in the same cycle are the transmitter going active and the receive filter reaching its threshold. The busy condition must win, so the filter is cleared rather than allowed to fire. The bench provokes this by holding `ir_rx` high across the fall and the rise of `uart_txd`, then letting the pulse end a few clocks after transmission ends. It judges the result by seeing `uart_rxd` stay 1 for the whole window. A later full-width pulse must still be accepted normally.

// File: rtl/sir_pkg.sv
package sir_pkg;
    localparam int OVS         = 16;
    localparam int PULSE_FIRST = 7;
    localparam int PULSE_LAST  = 9;
    localparam int LP_PERIODS  = 3;
    localparam int DIV_W       = 8;
    localparam int DIVE_W      = DIV_W + 1;

    typedef enum logic {
        LINK_RAW = 1'b0,
        LINK_SIR = 1'b1
    } link_e;

    typedef struct packed {
        link_e link;
        logic  fixed_width;
        logic [DIVE_W-1:0] div_n;
    } sir_cfg_t;

    function automatic logic [DIVE_W-1:0] div_decode(input logic [DIV_W-1:0] d);
        if (d == '0)
            return DIVE_W'(1) << DIV_W;
        return {1'b0, d};
    endfunction
endpackage

// File: rtl/sir_tx_enc.sv
module sir_tx_enc
    import sir_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  sir_cfg_t cfg,
    input  logic     txd,
    output logic     ir_out,
    output logic     busy
);
    localparam int PH_W  = $clog2(OVS);
    localparam int LPC_W = $clog2(LP_PERIODS * (2 ** DIV_W) + 1);

    logic             txd_r;
    logic [PH_W-1:0]  phase;
    logic [LPC_W-1:0] lp_cnt;
    logic             level_change;
    logic             lp_start;
    logic             in_window;
    logic             sir_on;

    assign sir_on       = (cfg.link == LINK_SIR);
    assign level_change = (txd != txd_r);
    assign lp_start     = sir_on && cfg.fixed_width && !txd_r && !level_change
                          && tick && (phase == PH_W'(PULSE_FIRST - 1));
    assign in_window    = (phase >= PH_W'(PULSE_FIRST)) && (phase <= PH_W'(PULSE_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            txd_r  <= 1'b1;
            phase  <= '0;
            lp_cnt <= '0;
        end else begin
            txd_r <= txd;
            if (level_change)
                phase <= '0;
            else if (tick)
                phase <= (phase == PH_W'(OVS - 1)) ? '0 : phase + 1'b1;

            if (!sir_on || !cfg.fixed_width)
                lp_cnt <= '0;
            else if (lp_start)
                lp_cnt <= LPC_W'(LP_PERIODS) * LPC_W'(cfg.div_n);
            else if (lp_cnt != '0)
                lp_cnt <= lp_cnt - 1'b1;
        end
    end

    always_comb begin
        if (!sir_on)
            ir_out = 1'b0;
        else if (cfg.fixed_width)
            ir_out = (lp_cnt != '0);
        else
            ir_out = !txd_r && in_window;
    end

    assign busy = sir_on && (!txd_r || (lp_cnt != '0));
endmodule

// File: rtl/sir_rx_dec.sv
module sir_rx_dec
    import sir_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  sir_cfg_t cfg,
    input  logic     busy,
    input  logic     ir_in,
    output logic     nrz
);
    localparam int BL_W = $clog2(OVS + 1);

    logic [1:0]        sync_q;
    logic [DIVE_W-1:0] high_cnt;
    logic [BL_W-1:0]   bit_left;
    logic              rx_hi;
    logic              hold_off;
    logic              qualified;

    assign rx_hi     = sync_q[1];
    assign hold_off  = (cfg.link != LINK_SIR) || busy;
    assign qualified = !hold_off && rx_hi && (high_cnt == cfg.div_n - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            high_cnt <= '0;
            bit_left <= '0;
        end else begin
            sync_q <= {sync_q[0], ir_in};

            if (hold_off || !rx_hi)
                high_cnt <= '0;
            else if (high_cnt != cfg.div_n)
                high_cnt <= high_cnt + 1'b1;

            if (hold_off)
                bit_left <= '0;
            else if (qualified)
                bit_left <= BL_W'(OVS);
            else if (tick && (bit_left != '0))
                bit_left <= bit_left - 1'b1;
        end
    end

    assign nrz = (bit_left == '0);
endmodule

// File: rtl/sir_codec.sv
module sir_codec
    import sir_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             baud_tick16,
    input  logic             sir_mode,
    input  logic             lp_mode,
    input  logic [DIV_W-1:0] lp_div,
    input  logic             uart_txd,
    output logic             uart_rxd,
    input  logic             ir_rx,
    output logic             ir_tx
);
    sir_cfg_t cfg;
    logic     enc_out;
    logic     dec_nrz;
    logic     tx_busy;

    always_comb begin
        cfg.link        = sir_mode ? LINK_SIR : LINK_RAW;
        cfg.fixed_width = lp_mode;
        cfg.div_n       = div_decode(lp_div);
    end

    sir_tx_enc i_tx (
        .clk    (clk),
        .rst    (rst),
        .tick   (baud_tick16),
        .cfg    (cfg),
        .txd    (uart_txd),
        .ir_out (enc_out),
        .busy   (tx_busy)
    );

    sir_rx_dec i_rx (
        .clk   (clk),
        .rst   (rst),
        .tick  (baud_tick16),
        .cfg   (cfg),
        .busy  (tx_busy),
        .ir_in (ir_rx),
        .nrz   (dec_nrz)
    );

    assign ir_tx    = (cfg.link == LINK_SIR) ? enc_out : uart_txd;
    assign uart_rxd = (cfg.link == LINK_SIR) ? dec_nrz : ir_rx;
endmodule

// File: rtl/sir_codec_chk.sv
module sir_codec_chk (
    input logic clk,
    input logic rst,
    input logic sir_mode,
    input logic lp_mode,
    input logic uart_txd,
    input logic uart_rxd,
    input logic ir_rx,
    input logic ir_tx
);
    // R9: raw link, transmit side
    a_r9_tx_follows: assert property (@(posedge clk) disable iff (rst)
        !sir_mode |-> (ir_tx == uart_txd));

    // R9: raw link, receive side
    a_r9_rx_follows: assert property (@(posedge clk) disable iff (rst)
        !sir_mode |-> (uart_rxd == ir_rx));

    // R3: a one bit in bit-relative width emits nothing
    a_r3_no_pulse_on_one: assert property (@(posedge clk) disable iff (rst)
        (sir_mode && !lp_mode && $past(sir_mode) && $past(uart_txd)) |-> !ir_tx);

    // R8: receiver stays idle while the transmit line is low
    a_r8_rx_quiet_in_tx: assert property (@(posedge clk) disable iff (rst)
        (sir_mode && $past(sir_mode) && !$past(uart_txd) && !$past(uart_txd, 2)) |-> uart_rxd);

    // R6: a falling receive level needs a received pulse behind it
    a_r6_fall_needs_pulse: assert property (@(posedge clk) disable iff (rst)
        (sir_mode && $past(sir_mode) && $fell(uart_rxd)) |-> $past(ir_rx, 3));
endmodule

bind sir_codec sir_codec_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .sir_mode (sir_mode),
    .lp_mode  (lp_mode),
    .uart_txd (uart_txd),
    .uart_rxd (uart_rxd),
    .ir_rx    (ir_rx),
    .ir_tx    (ir_tx)
);

// File: tb/test_sir_codec.sv
module test_sir_codec;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick16 = 1'b0;
    logic       sir_mode = 1'b1;
    logic       lp_mode = 1'b0;
    logic [7:0] lp_div = 8'd4;
    logic       uart_txd = 1'b1;
    logic       uart_rxd;
    logic       ir_rx = 1'b0;
    logic       ir_tx;

    int n_chk = 0;
    int n_fail = 0;
    int tick_gap = 10;

    sir_codec i_sir_codec (
        .clk         (clk),
        .rst         (rst),
        .baud_tick16 (baud_tick16),
        .sir_mode    (sir_mode),
        .lp_mode     (lp_mode),
        .lp_div      (lp_div),
        .uart_txd    (uart_txd),
        .uart_rxd    (uart_rxd),
        .ir_rx       (ir_rx),
        .ir_tx       (ir_tx)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        int tgc;
        tgc = 0;
        forever begin
            @(negedge clk);
            if (tgc >= tick_gap - 1) begin
                baud_tick16 = 1'b1;
                tgc = 0;
            end else begin
                baud_tick16 = 1'b0;
                tgc = tgc + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drop txd for nz bits, then raise it for one more bit; record ir_tx highs.
    task automatic tx_measure(input int nz, output int hi, output int first, output int last);
        int zlen;
        zlen = nz * OVS * tick_gap;
        hi = 0;
        first = -1;
        last = -1;
        @(negedge clk);
        uart_txd = 1'b0;
        for (int i = 0; i < zlen + OVS * tick_gap; i++) begin
            @(negedge clk);
            if (ir_tx) begin
                hi++;
                if (first < 0) first = i;
                last = i;
            end
            if (i == zlen - 1) uart_txd = 1'b1;
        end
    endtask

    task automatic rx_pulse(input int len);
        @(negedge clk);
        ir_rx = 1'b1;
        idle(len);
        ir_rx = 1'b0;
    endtask

    task automatic count_rx_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!uart_rxd) lows++;
        end
    endtask

    task automatic t_reset_idle();
        chk(ir_tx == 1'b0, "R1 ir_tx idle", int'(ir_tx), 0);
        chk(uart_rxd == 1'b1, "R1 uart_rxd idle", int'(uart_rxd), 1);
    endtask

    task automatic t_passthrough();
        @(negedge clk);
        sir_mode = 1'b0;
        uart_txd = 1'b0;
        #1;
        chk(ir_tx == 1'b0, "R9 tx raw low", int'(ir_tx), 0);
        uart_txd = 1'b1;
        ir_rx = 1'b1;
        #1;
        chk(ir_tx == 1'b1, "R9 tx raw high", int'(ir_tx), 1);
        chk(uart_rxd == 1'b1, "R9 rx raw high", int'(uart_rxd), 1);
        ir_rx = 1'b0;
        #1;
        chk(uart_rxd == 1'b0, "R9 rx raw low", int'(uart_rxd), 0);
        @(negedge clk);
        sir_mode = 1'b1;
        idle(4);
    endtask

    task automatic t_tx_normal();
        int hi, first, last;
        lp_mode = 1'b0;
        tick_gap = 10;
        idle(20);
        tx_measure(1, hi, first, last);
        chk(hi == 3 * tick_gap, "R2 width one zero", hi, 3 * tick_gap);
        chk(first > 6 * tick_gap, "R2 pulse not before tick 7", first, 6 * tick_gap + 1);
        chk(last < 10 * tick_gap, "R2 pulse ends by tick 10", last, 10 * tick_gap - 1);
        idle(20);
        tx_measure(2, hi, first, last);
        chk(hi == 6 * tick_gap, "R2 two zero bits", hi, 6 * tick_gap);
    endtask

    task automatic t_tx_ones();
        int hi;
        hi = 0;
        uart_txd = 1'b1;
        for (int i = 0; i < 2 * OVS * tick_gap; i++) begin
            @(negedge clk);
            if (ir_tx) hi++;
        end
        chk(hi == 0, "R3 ones give no pulse", hi, 0);
    endtask

    task automatic t_tx_lowpower();
        int hi, first, last;
        lp_mode = 1'b1;
        lp_div = 8'd5;
        tick_gap = 10;
        idle(20);
        tx_measure(1, hi, first, last);
        chk(hi == 15, "R4 width at gap 10", hi, 15);
        chk(first > 6 * tick_gap, "R4 starts at tick 7", first, 6 * tick_gap + 1);
        tick_gap = 20;
        idle(40);
        tx_measure(1, hi, first, last);
        chk(hi == 15, "R4 width at gap 20", hi, 15);
        lp_div = 8'd0;
        tick_gap = 80;
        idle(200);
        tx_measure(1, hi, first, last);
        chk(hi == 768, "R5 divisor zero width", hi, 768);
        lp_mode = 1'b0;
        lp_div = 8'd4;
        tick_gap = 10;
        idle(20);
    endtask

    task automatic t_rx();
        int lows;
        lp_div = 8'd4;
        idle(10);
        rx_pulse(3);
        count_rx_low(40, lows);
        chk(lows == 0, "R7 short pulse rejected", lows, 0);
        rx_pulse(4);
        idle(4);
        chk(uart_rxd == 1'b0, "R6 pulse of N accepted", int'(uart_rxd), 0);
        idle(13 * tick_gap);
        chk(uart_rxd == 1'b0, "R6 low held through bit", int'(uart_rxd), 0);
        idle(4 * tick_gap);
        chk(uart_rxd == 1'b1, "R6 returns high after 16 ticks", int'(uart_rxd), 1);
        lp_div = 8'd0;
        idle(10);
        rx_pulse(255);
        count_rx_low(40, lows);
        chk(lows == 0, "R5 filter 256 rejects 255", lows, 0);
        rx_pulse(256);
        idle(4);
        chk(uart_rxd == 1'b0, "R5 filter 256 accepts 256", int'(uart_rxd), 0);
        idle(20 * tick_gap);
        lp_div = 8'd4;
    endtask

    task automatic t_half_duplex();
        int lows, l2;
        lp_mode = 1'b0;
        idle(10);
        @(negedge clk);
        uart_txd = 1'b0;
        idle(3);
        ir_rx = 1'b1;
        count_rx_low(40, lows);
        ir_rx = 1'b0;
        count_rx_low(40, l2);
        chk(lows + l2 == 0, "R8 rx ignored while sending", lows + l2, 0);
        ir_rx = 1'b1;
        count_rx_low(OVS * tick_gap - 100, lows);
        uart_txd = 1'b1;
        idle(2);
        ir_rx = 1'b0;
        count_rx_low(40, l2);
        chk(lows + l2 == 0, "R8 overlap tail rejected", lows + l2, 0);
        rx_pulse(5);
        idle(4);
        chk(uart_rxd == 1'b0, "R8 fresh pulse accepted after tx", int'(uart_rxd), 0);
        idle(20 * tick_gap);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(3);
        t_reset_idle();
        t_passthrough();
        t_tx_normal();
        t_tx_ones();
        t_tx_lowpower();
        t_rx();
        t_half_duplex();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule